// File: doc/BRIEF.md
# Operand-two barrel shifter

This combinational unit forms the second ALU operand and the shifter carry for a 32-bit datapath with a 26-bit program counter. It has two forms. In the immediate form an 8-bit constant is rotated right by twice a 4-bit rotate field. In the register form a source word is shifted by one of four shift kinds. The amount comes from a 5-bit field in the instruction or from the low byte of a second register.

The unit settles the edge cases that software relies on. These are amounts of zero, exactly the word width, and more than the word width. It also handles the instruction-field zero encodings that stand for a 32-bit shift or for a one-bit rotate through carry. The incoming carry flag enters the unit and a carry-out leaves it. Register fetch, the ALU and flag writeback sit around the unit and are not part of it.

Top module: `op2_shifter`

## Requirements
- R1: With `sel_imm`=1, `operand` equals `imm_byte` zero-extended to 32 bits and rotated right by 2×`imm_rot`.
- R2: With `sel_imm`=1, `carry_out` equals `carry_in` when `imm_rot`=0, and equals `operand[31]` otherwise.
- R3: With `sel_imm`=0 and `amt_from_reg`=1, only `amt_reg[7:0]` sets the amount. Bits 31:8 have no effect.
- R4: A register amount of 0, for any shift kind, gives `operand`=`src_val` and `carry_out`=`carry_in`.
- R5: `shift_kind` codes are 00 logical left, 01 logical right, 10 arithmetic right and 11 rotate right. For logical left by n in 1..31, the result is `src_val`<<n and the carry is `src_val[32-n]`. An immediate amount of 0 with logical left passes the value through and keeps `carry_in`.
- R6: Logical left by 32 gives 0 with carry `src_val[0]`. Logical left by more than 32 gives 0 with carry 0.
- R7: For logical right by n in 1..31, the result is `src_val`>>n and the carry is `src_val[n-1]`. An immediate amount of 0 with logical right acts as a shift by 32.
- R8: Logical right by 32 gives 0 with carry `src_val[31]`. Logical right by more than 32 gives 0 with carry 0.
- R9: Arithmetic right by n in 1..31 shifts in copies of bit 31, with carry `src_val[n-1]`. By 32 or more, every bit equals `src_val[31]` and so does the carry. An immediate amount of 0 acts as 32.
- R10: For rotate right, a nonzero register amount n acts as a rotate by n mod 32. When n mod 32 is 0, the value is unchanged and the carry is `src_val[31]`. Otherwise the carry is `src_val[(n mod 32)-1]`.
- R11: Rotate right with an immediate amount of 0 is a one-bit rotate through carry: `operand`={`carry_in`,`src_val[31:1]`} and `carry_out`=`src_val[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sel_imm | input | 1 | 1 selects the rotated-immediate form |
| imm_byte | input | 8 | Immediate constant |
| imm_rot | input | 4 | Rotate field (rotation is twice this value) |
| src_val | input | 32 | Register value to shift |
| shift_kind | input | 2 | Shift kind code |
| amt_from_reg | input | 1 | 1 takes the amount from `amt_reg` |
| amt_imm | input | 5 | Immediate shift amount |
| amt_reg | input | 32 | Register holding the amount (low byte used) |
| carry_in | input | 1 | Incoming carry flag |
| operand | output | 32 | Second ALU operand |
| carry_out | output | 1 | Shifter carry-out |

## Verification
Byte truncation of the register amount (R3) and the zero-amount pass-through (R4) can act on the same input. This happens when `amt_reg` has a zero low byte but nonzero upper bits. The bench drives 0xFFFFFF00 and expects an untouched value and carry. It then drives 0x104 and expects a shift by exactly 4. In the same way, the immediate zero encodings (R5, R7, R9, R11) are each applied to the same source word. Each must give a different result, which is compared bit-for-bit with the hand-derived value.

// File: rtl/op2_pkg.sv
package op2_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned AMT_W  = 8;

    typedef enum logic [1:0] {
        SHK_LSL = 2'b00,
        SHK_LSR = 2'b01,
        SHK_ASR = 2'b10,
        SHK_ROR = 2'b11
    } shift_kind_e;

    // Resolved shift request after the amount source and the zero encodings are decoded
    typedef struct packed {
        shift_kind_e      kind;
        logic [AMT_W-1:0] amount;
        logic             pass;   // value and carry go through untouched
        logic             rrx;    // one-bit rotate through carry
    } shift_req_t;

    typedef struct packed {
        logic [WORD_W-1:0] value;
        logic              carry;
    } op2_res_t;

endpackage

// File: rtl/op2_imm_rot.sv
module op2_imm_rot
    import op2_pkg::*;
#(
    parameter int unsigned DATA_W = WORD_W,
    parameter int unsigned IMM_W  = 8,
    parameter int unsigned ROT_W  = 4
) (
    input  logic [IMM_W-1:0] imm_byte,
    input  logic [ROT_W-1:0] imm_rot,
    input  logic             carry_in,
    output op2_res_t         res
);
    localparam int unsigned SH_W = $clog2(DATA_W);

    logic [2*DATA_W-1:0] doubled;
    logic [SH_W-1:0]     rot_amt;

    always_comb begin
        rot_amt   = SH_W'({imm_rot, 1'b0});
        doubled   = {{(DATA_W-IMM_W){1'b0}}, imm_byte, {(DATA_W-IMM_W){1'b0}}, imm_byte} >> rot_amt;
        res.value = doubled[DATA_W-1:0];
        res.carry = (imm_rot == '0) ? carry_in : doubled[DATA_W-1];
    end
endmodule

// File: rtl/op2_amount_sel.sv
module op2_amount_sel
    import op2_pkg::*;
#(
    parameter int unsigned DATA_W = WORD_W
) (
    input  shift_kind_e               kind,
    input  logic                      from_reg,
    input  logic [$clog2(DATA_W)-1:0] amt_imm,
    input  logic [AMT_W-1:0]          amt_byte,
    output shift_req_t                req
);
    always_comb begin
        req.kind   = kind;
        req.amount = '0;
        req.pass   = 1'b0;
        req.rrx    = 1'b0;
        if (from_reg) begin
            req.amount = amt_byte;
            req.pass   = (amt_byte == '0);
        end else if (amt_imm != '0) begin
            req.amount = AMT_W'(amt_imm);
        end else begin
            unique case (kind)
                SHK_LSL: req.pass = 1'b1;
                SHK_LSR,
                SHK_ASR: req.amount = AMT_W'(DATA_W);
                SHK_ROR: req.rrx = 1'b1;
                default: req.pass = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/op2_shift_core.sv
module op2_shift_core
    import op2_pkg::*;
#(
    parameter int unsigned DATA_W = WORD_W
) (
    input  logic [DATA_W-1:0] src_val,
    input  shift_req_t        req,
    input  logic              carry_in,
    output op2_res_t          res
);
    localparam int unsigned SH_W = $clog2(DATA_W);

    logic [SH_W-1:0]     sh;
    logic                at_width;
    logic                over_width;
    logic [2*DATA_W-1:0] rot_wide;

    always_comb begin
        sh         = req.amount[SH_W-1:0];
        at_width   = (req.amount == AMT_W'(DATA_W));
        over_width = (req.amount > AMT_W'(DATA_W));
        rot_wide   = {src_val, src_val} >> sh;
        res.value  = src_val;
        res.carry  = carry_in;
        if (req.rrx) begin
            res.value = {carry_in, src_val[DATA_W-1:1]};
            res.carry = src_val[0];
        end else if (!req.pass) begin
            unique case (req.kind)
                SHK_LSL: begin
                    if (at_width) begin
                        res.value = '0;
                        res.carry = src_val[0];
                    end else if (over_width) begin
                        res.value = '0;
                        res.carry = 1'b0;
                    end else begin
                        res.value = src_val << sh;
                        res.carry = src_val[SH_W'(DATA_W) - sh];
                    end
                end
                SHK_LSR: begin
                    if (at_width) begin
                        res.value = '0;
                        res.carry = src_val[DATA_W-1];
                    end else if (over_width) begin
                        res.value = '0;
                        res.carry = 1'b0;
                    end else begin
                        res.value = src_val >> sh;
                        res.carry = src_val[sh - 1'b1];
                    end
                end
                SHK_ASR: begin
                    if (at_width || over_width) begin
                        res.value = {DATA_W{src_val[DATA_W-1]}};
                        res.carry = src_val[DATA_W-1];
                    end else begin
                        res.value = $unsigned($signed(src_val) >>> sh);
                        res.carry = src_val[sh - 1'b1];
                    end
                end
                default: begin
                    if (sh == '0) begin
                        res.value = src_val;
                        res.carry = src_val[DATA_W-1];
                    end else begin
                        res.value = rot_wide[DATA_W-1:0];
                        res.carry = src_val[sh - 1'b1];
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/op2_shifter.sv
module op2_shifter
    import op2_pkg::*;
(
    input  logic        sel_imm,
    input  logic [7:0]  imm_byte,
    input  logic [3:0]  imm_rot,
    input  logic [31:0] src_val,
    input  logic [1:0]  shift_kind,
    input  logic        amt_from_reg,
    input  logic [4:0]  amt_imm,
    input  logic [31:0] amt_reg,
    input  logic        carry_in,
    output logic [31:0] operand,
    output logic        carry_out
);
    shift_req_t req;
    op2_res_t   imm_res;
    op2_res_t   reg_res;
    logic       unused_amt_hi;

    assign unused_amt_hi = ^amt_reg[WORD_W-1:AMT_W];

    op2_imm_rot #(.DATA_W(WORD_W), .IMM_W(8), .ROT_W(4)) imm_i (
        .imm_byte (imm_byte),
        .imm_rot  (imm_rot),
        .carry_in (carry_in),
        .res      (imm_res)
    );

    op2_amount_sel #(.DATA_W(WORD_W)) amt_i (
        .kind     (shift_kind_e'(shift_kind)),
        .from_reg (amt_from_reg),
        .amt_imm  (amt_imm),
        .amt_byte (amt_reg[AMT_W-1:0]),
        .req      (req)
    );

    op2_shift_core #(.DATA_W(WORD_W)) core_i (
        .src_val  (src_val),
        .req      (req),
        .carry_in (carry_in),
        .res      (reg_res)
    );

    always_comb begin
        if (sel_imm) begin
            operand   = imm_res.value;
            carry_out = imm_res.carry;
        end else begin
            operand   = reg_res.value;
            carry_out = reg_res.carry;
        end
    end
endmodule

// File: rtl/op2_shifter_chk.sv
module op2_shifter_chk (
    input logic        sel_imm,
    input logic [7:0]  imm_byte,
    input logic [3:0]  imm_rot,
    input logic [31:0] src_val,
    input logic [1:0]  shift_kind,
    input logic        amt_from_reg,
    input logic [4:0]  amt_imm,
    input logic [31:0] amt_reg,
    input logic        carry_in,
    input logic [31:0] operand,
    input logic        carry_out
);
    logic known;
    logic reg_form;

    always_comb begin
        known    = !$isunknown({sel_imm, imm_byte, imm_rot, src_val, shift_kind,
                                amt_from_reg, amt_imm, amt_reg, carry_in,
                                operand, carry_out});
        reg_form = known && !sel_imm;
        if (known && sel_imm) begin
            a_r1_imm_bits_kept: assert ($countones(operand) == $countones(imm_byte))
                else $error("R1 rotated immediate lost or gained bits");
            a_r2_imm_carry: assert (carry_out == ((imm_rot == 4'd0) ? carry_in : operand[31]))
                else $error("R2 immediate carry rule broken");
        end
        if (reg_form && amt_from_reg && amt_reg[7:0] == 8'd0) begin
            a_r4_zero_pass: assert (operand == src_val && carry_out == carry_in)
                else $error("R4 zero register amount altered data");
        end
        if (reg_form && amt_from_reg && shift_kind == 2'b00 && amt_reg[7:0] > 8'd32) begin
            a_r6_lsl_over: assert (operand == 32'd0 && !carry_out)
                else $error("R6 oversize left shift");
        end
        if (reg_form && amt_from_reg && shift_kind == 2'b01 && amt_reg[7:0] > 8'd32) begin
            a_r8_lsr_over: assert (operand == 32'd0 && !carry_out)
                else $error("R8 oversize right shift");
        end
        if (reg_form && shift_kind == 2'b10 &&
            ((amt_from_reg && amt_reg[7:0] >= 8'd32) || (!amt_from_reg && amt_imm == 5'd0))) begin
            a_r9_asr_fill: assert (operand == {32{src_val[31]}} && carry_out == src_val[31])
                else $error("R9 arithmetic fill wrong");
        end
        if (reg_form && shift_kind == 2'b11 && !amt_from_reg && amt_imm == 5'd0) begin
            a_r11_rrx: assert (operand == {carry_in, src_val[31:1]} && carry_out == src_val[0])
                else $error("R11 rotate through carry wrong");
        end
        if (reg_form && shift_kind == 2'b11 && (amt_from_reg || amt_imm != 5'd0)) begin
            a_r10_ror_bits_kept: assert ($countones(operand) == $countones(src_val))
                else $error("R10 rotation lost bits");
        end
    end
endmodule

bind op2_shifter op2_shifter_chk chk_i (
    .sel_imm      (sel_imm),
    .imm_byte     (imm_byte),
    .imm_rot      (imm_rot),
    .src_val      (src_val),
    .shift_kind   (shift_kind),
    .amt_from_reg (amt_from_reg),
    .amt_imm      (amt_imm),
    .amt_reg      (amt_reg),
    .carry_in     (carry_in),
    .operand      (operand),
    .carry_out    (carry_out)
);

// File: tb/op2_shifter_tb_top.sv
module op2_shifter_tb_top;
    logic        clk = 1'b0;
    logic        sel_imm = 1'b0;
    logic [7:0]  imm_byte = '0;
    logic [3:0]  imm_rot = '0;
    logic [31:0] src_val = '0;
    logic [1:0]  shift_kind = '0;
    logic        amt_from_reg = 1'b0;
    logic [4:0]  amt_imm = '0;
    logic [31:0] amt_reg = '0;
    logic        carry_in = 1'b0;
    logic [31:0] operand;
    logic        carry_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    localparam logic [31:0] PAT = 32'hC000_0003;

    always #2.5 clk = ~clk;

    op2_shifter dut_i (
        .sel_imm(sel_imm), .imm_byte(imm_byte), .imm_rot(imm_rot),
        .src_val(src_val), .shift_kind(shift_kind), .amt_from_reg(amt_from_reg),
        .amt_imm(amt_imm), .amt_reg(amt_reg), .carry_in(carry_in),
        .operand(operand), .carry_out(carry_out)
    );

    task automatic chk(input string req, input logic [31:0] exp_v, input logic exp_c);
        #1;
        checks++;
        if (operand !== exp_v || carry_out !== exp_c) begin
            failures++;
            $display("FAIL %s: got %h/%b expected %h/%b", req, operand, carry_out, exp_v, exp_c);
        end
    endtask

    task automatic drive_reg(input logic [1:0] k, input logic frm, input logic [4:0] ai,
                             input logic [31:0] ar, input logic ci);
        @(negedge clk);
        sel_imm = 1'b0; src_val = PAT; shift_kind = k;
        amt_from_reg = frm; amt_imm = ai; amt_reg = ar; carry_in = ci;
    endtask

    task automatic drive_imm(input logic [7:0] b, input logic [3:0] r, input logic ci);
        @(negedge clk);
        sel_imm = 1'b1; imm_byte = b; imm_rot = r; carry_in = ci;
        src_val = 32'hDEAD_BEEF; amt_from_reg = 1'b1; amt_reg = 32'h5;
    endtask

    task automatic t_immediate();
        drive_imm(8'hFF, 4'd0, 1'b1); chk("R2", 32'h0000_00FF, 1'b1);
        drive_imm(8'hFF, 4'd0, 1'b0); chk("R2", 32'h0000_00FF, 1'b0);
        drive_imm(8'hFF, 4'd4, 1'b0); chk("R1", 32'hFF00_0000, 1'b1);
        drive_imm(8'h01, 4'd1, 1'b1); chk("R1", 32'h4000_0000, 1'b0);
        drive_imm(8'h03, 4'd1, 1'b0); chk("R2", 32'hC000_0000, 1'b1);
    endtask

    task automatic t_amount_byte();
        drive_reg(2'b00, 1'b1, 5'd0, 32'hFFFF_FF00, 1'b1); chk("R4", PAT, 1'b1);
        drive_reg(2'b11, 1'b1, 5'd0, 32'h0000_0000, 1'b0); chk("R4", PAT, 1'b0);
        drive_reg(2'b00, 1'b1, 5'd0, 32'h0000_0104, 1'b1); chk("R3", 32'h0000_0030, 1'b0);
    endtask

    task automatic t_left();
        drive_reg(2'b00, 1'b0, 5'd0, 32'd0, 1'b0);  chk("R5", PAT, 1'b0);
        drive_reg(2'b00, 1'b0, 5'd1, 32'd0, 1'b0);  chk("R5", 32'h8000_0006, 1'b1);
        drive_reg(2'b00, 1'b1, 5'd0, 32'd32, 1'b0); chk("R6", 32'h0, 1'b1);
        drive_reg(2'b00, 1'b1, 5'd0, 32'd33, 1'b1); chk("R6", 32'h0, 1'b0);
    endtask

    task automatic t_right();
        drive_reg(2'b01, 1'b0, 5'd1, 32'd0, 1'b0);  chk("R7", 32'h6000_0001, 1'b1);
        drive_reg(2'b01, 1'b0, 5'd0, 32'd0, 1'b0);  chk("R7", 32'h0, 1'b1);
        drive_reg(2'b01, 1'b1, 5'd0, 32'd32, 1'b0); chk("R8", 32'h0, 1'b1);
        drive_reg(2'b01, 1'b1, 5'd0, 32'd40, 1'b1); chk("R8", 32'h0, 1'b0);
    endtask

    task automatic t_arith();
        drive_reg(2'b10, 1'b0, 5'd1, 32'd0, 1'b0);   chk("R9", 32'hE000_0001, 1'b1);
        drive_reg(2'b10, 1'b0, 5'd2, 32'd0, 1'b0);   chk("R9", 32'hF000_0000, 1'b1);
        drive_reg(2'b10, 1'b0, 5'd0, 32'd0, 1'b0);   chk("R9", 32'hFFFF_FFFF, 1'b1);
        drive_reg(2'b10, 1'b1, 5'd0, 32'd200, 1'b0); chk("R9", 32'hFFFF_FFFF, 1'b1);
    endtask

    task automatic t_rotate();
        drive_reg(2'b11, 1'b0, 5'd4, 32'd0, 1'b1);  chk("R10", 32'h3C00_0000, 1'b0);
        drive_reg(2'b11, 1'b1, 5'd0, 32'd32, 1'b0); chk("R10", PAT, 1'b1);
        drive_reg(2'b11, 1'b1, 5'd0, 32'd36, 1'b1); chk("R10", 32'h3C00_0000, 1'b0);
        drive_reg(2'b11, 1'b0, 5'd0, 32'd0, 1'b0);  chk("R11", 32'h6000_0001, 1'b1);
        drive_reg(2'b11, 1'b0, 5'd0, 32'd0, 1'b1);  chk("R11", 32'hE000_0001, 1'b1);
    endtask

    initial begin
        t_immediate();
        t_amount_byte();
        t_left();
        t_right();
        t_arith();
        t_rotate();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule